// File: doc/BRIEF.md
# Receive I/Q Imbalance and DC Offset Corrector

This block sits at the tail of a zero-IF receive path and cleans up the in-phase and quadrature samples that come from a dual converter. Every upstream analog mismatch lands here, where it can be fixed digitally in one place. Each channel first passes through a leaky-integrator DC blocker. The block assumes the traffic carries no DC, so the offset removal does not harm the signal.

Two blind adaptive loops then correct the quadrature channel. A gain coefficient `g` scales Q until the power difference I² − Q² averages to zero. A skew coefficient `p` mixes I into Q until the correlation I·Q averages to zero. Both error terms are taken from the corrected outputs, so each loop is closed. The corrected Q is `g·(Q + p·I)`. I passes straight through after DC removal.

A small register port sets the DC time constant, the two loop step sizes and the two loop enables. It also reads back both coefficients. A loop that is switched off keeps its last coefficient.

Top module: `iq_imbalance_fix`

## Requirements
- R1: `out_valid` goes high in the cycle after each cycle with `in_valid` high, and low otherwise. While `in_valid` is low, `out_i` and `out_q` keep their values.
- R2: Each channel keeps a 2^-16 scaled accumulator `a`, which is 0 after reset. For each valid sample `x`, it forms `d = x·2^16 − a`, gives `y = floor(d / 2^16)`, then sets `a += floor(d / 2^K)`. `out_i` equals `y` of the I channel.
- R3: K is config bits [4:0]. A written value below 8 is stored as 8, and a value above 16 is stored as 16. Reading the config shows the stored value.
- R4: With `g` and `p` the coefficients in force, `out_q = sat16(floor(g·(y_q + floor(p·y_i / 2^16)) / 2^16))`. Here `sat16` clamps to [−32768, 32767].
- R5: When the gain loop is enabled (config bit 24), each output sample updates `g += floor((out_i² − out_q²) / 2^Sg)`. Sg is config bits [12:8]. The result is clamped to [−262144, 262143]. Without an output sample, neither coefficient changes.
- R6: When the skew loop is enabled (config bit 25), each output sample updates `p −= floor(out_i·out_q / 2^Sp)`. Sp is config bits [20:16]. The result is clamped to the same range as `g`.
- R7: A disabled loop holds its coefficient unchanged, whatever samples arrive.
- R8: Reset gives `g` = 65536 (1.0), `p` = 0, zero outputs, `out_valid` low, K = 10, Sg = Sp = 16, and both loops disabled.
- R9: Address 0 reads the config, with unused bits reading 0. Address 1 reads `g` and address 2 reads `p`, both sign-extended to 32 bits. Address 3 reads 0. Only address 0 is writable.
- R10: For a zero-mean four-phase tone whose Q is scaled by 0.5 and mixed with 0.25·I, both loops at step 16 settle near `g` = 2.0 and `p` = −0.25.
- R11: A constant input decays at the output to within ±1 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 14 | In-phase sample, signed |
| in_q | input | 14 | Quadrature sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Corrected in-phase, signed |
| out_q | output | 16 | Corrected quadrature, signed |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational |

## Verification
The bench goes after the arithmetic corners where a wrong design shows up at once:
- Floor rounding of negative DC residues. An arithmetic shift replaced by a logical one, or rounding toward zero, moves `out_i` off by one LSB or wildly.
- Coefficient clamping, with step shift 0 at full-scale input. Missing saturation wraps `g` or `p` to the opposite sign.
- Output saturation when `g` and `p` both sit at their limits. Wrap-around would flip the sign of `out_q`.
- The sign of each loop update. An inverted sign makes the blind tone drive `g` and `p` away from 2.0 and −0.25 instead of toward them.
- The frozen-loop and idle-cycle cases. A design that adapts without a sample, or while disabled, changes the coefficients it reads back.
- The clamping of K at both ends.

// File: rtl/iq_fix_pkg.sv
// Shared types and helpers for the I/Q imbalance corrector.
// Assumes all internal arithmetic fits in WIDE signed bits.
package iq_fix_pkg;
    localparam int WIDE      = 48;
    localparam int SHIFT_W   = 5;
    localparam int K_MIN     = 8;
    localparam int K_MAX     = 16;

    typedef logic signed [WIDE-1:0] wide_t;

    typedef struct packed {
        logic               en_p;
        logic               en_g;
        logic [SHIFT_W-1:0] mu_p;
        logic [SHIFT_W-1:0] mu_g;
        logic [SHIFT_W-1:0] dc_k;
    } iq_cfg_t;

    // Clamp a wide signed value to the range of a w-bit signed number.
    function automatic wide_t clamp_w(input wide_t v, input int w);
        wide_t hi;
        wide_t lo;
        hi = (wide_t'(1) <<< (w - 1)) - wide_t'(1);
        lo = -(wide_t'(1) <<< (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // Force the DC time-constant shift into its legal window.
    function automatic logic [SHIFT_W-1:0] clamp_k(input logic [SHIFT_W-1:0] k);
        if (int'(k) < K_MIN) return SHIFT_W'(K_MIN);
        if (int'(k) > K_MAX) return SHIFT_W'(K_MAX);
        return k;
    endfunction
endpackage

// File: rtl/iq_dc_block.sv
// One-channel DC blocker: a first-order leaky integrator tracks the mean,
// and the output is the input minus that mean. Assumes DC-free traffic.
// The accumulator carries FRAC fractional bits; the output is floored.
module iq_dc_block
    import iq_fix_pkg::*;
#(
    parameter int IN_W  = 14,
    parameter int FRAC  = 16,
    parameter int ACC_W = 32,
    parameter int Y_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic [IN_W-1:0]          x_in,
    input  logic [SHIFT_W-1:0]       k_shift,
    output logic signed [Y_W-1:0]    y_out
);
    logic signed [ACC_W-1:0] acc;
    wide_t                   x_w;
    wide_t                   diff;

    // Difference between the scaled sample and the running mean.
    always_comb begin
        x_w   = wide_t'($signed(x_in)) <<< FRAC;
        diff  = x_w - wide_t'(acc);
        y_out = Y_W'(diff >>> FRAC);
    end

    // Leak a 2^-K share of the difference into the mean on each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (smp_valid) begin
            acc <= acc + ACC_W'(diff >>> k_shift);
        end
    end
endmodule

// File: rtl/iq_coef_loop.sv
// Adaptive coefficient accumulator for one correction loop.
// Adds (or, when SUBTRACT is set, removes) err >>> shift on each update,
// saturating to COEF_W signed bits. It holds when upd is low.
module iq_coef_loop
    import iq_fix_pkg::*;
#(
    parameter int COEF_W   = 19,
    parameter int RST_VAL  = 0,
    parameter bit SUBTRACT = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     upd,
    input  wide_t                    err,
    input  logic [SHIFT_W-1:0]       shift,
    output logic signed [COEF_W-1:0] coef
);
    wide_t step;
    wide_t nxt;

    // Scaled error step for this update.
    assign step = err >>> shift;

    // Direction of the update is fixed per loop by SUBTRACT.
    generate
        if (SUBTRACT) begin : g_sub
            assign nxt = wide_t'(coef) - step;
        end else begin : g_add
            assign nxt = wide_t'(coef) + step;
        end
    endgenerate

    // Saturating coefficient register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coef <= COEF_W'(RST_VAL);
        end else if (upd) begin
            coef <= COEF_W'(clamp_w(nxt, COEF_W));
        end
    end
endmodule

// File: rtl/iq_imbalance_fix.sv
// Receive-side I/Q corrector: DC removal per channel, then blind gain and
// skew loops on Q, driven by I^2 - Q^2 and I*Q of the corrected output.
// One register stage from input to output; coefficients adapt one cycle
// after each output sample. Assumes signed two's-complement samples.
module iq_imbalance_fix
    import iq_fix_pkg::*;
#(
    parameter int IN_W   = 14,
    parameter int OUT_W  = 16,
    parameter int FRAC   = 16,
    parameter int COEF_W = 19,
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32,
    parameter int K_RST  = 10,
    parameter int MU_RST = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_i,
    input  logic [IN_W-1:0]   in_q,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_i,
    output logic [OUT_W-1:0]  out_q,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata
);
    localparam int Y_W    = IN_W + 2;
    localparam int G_ONE  = 1 << FRAC;

    iq_cfg_t                 cfg;
    logic                    cfg_en_g;
    logic                    cfg_en_p;
    logic signed [Y_W-1:0]   y_i;
    logic signed [Y_W-1:0]   y_q;
    logic signed [COEF_W-1:0] coef_g;
    logic signed [COEF_W-1:0] coef_p;
    wide_t                   skew_w;
    wide_t                   sum_w;
    wide_t                   gq_w;
    logic signed [OUT_W-1:0] i_nxt;
    logic signed [OUT_W-1:0] q_nxt;
    logic signed [OUT_W-1:0] oi_r;
    logic signed [OUT_W-1:0] oq_r;
    logic                    ov_r;
    wide_t                   err_g;
    wide_t                   err_p;

    assign cfg_en_g = cfg.en_g;
    assign cfg_en_p = cfg.en_p;

    // Configuration register with K clamped on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{en_p: 1'b0, en_g: 1'b0, mu_p: SHIFT_W'(MU_RST),
                     mu_g: SHIFT_W'(MU_RST), dc_k: SHIFT_W'(K_RST)};
        end else if (cfg_wr && cfg_addr == ADDR_W'(0)) begin
            cfg.dc_k <= clamp_k(cfg_wdata[4:0]);
            cfg.mu_g <= cfg_wdata[12:8];
            cfg.mu_p <= cfg_wdata[20:16];
            cfg.en_g <= cfg_wdata[24];
            cfg.en_p <= cfg_wdata[25];
        end
    end

    iq_dc_block #(.IN_W(IN_W), .FRAC(FRAC), .ACC_W(ACC_W), .Y_W(Y_W)) u_dc_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(in_valid), .x_in(in_i),
        .k_shift(cfg.dc_k), .y_out(y_i)
    );

    iq_dc_block #(.IN_W(IN_W), .FRAC(FRAC), .ACC_W(ACC_W), .Y_W(Y_W)) u_dc_q (
        .clk(clk), .rst_n(rst_n), .smp_valid(in_valid), .x_in(in_q),
        .k_shift(cfg.dc_k), .y_out(y_q)
    );

    // Correction: Q' = g * (Q + p * I), both terms floored, then saturated.
    always_comb begin
        skew_w = wide_t'(coef_p) * wide_t'(y_i);
        sum_w  = wide_t'(y_q) + (skew_w >>> FRAC);
        gq_w   = wide_t'(coef_g) * sum_w;
        q_nxt  = OUT_W'(clamp_w(gq_w >>> FRAC, OUT_W));
        i_nxt  = OUT_W'(clamp_w(wide_t'(y_i), OUT_W));
    end

    // Output stage: loads only on a valid input sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ov_r <= 1'b0;
            oi_r <= '0;
            oq_r <= '0;
        end else begin
            ov_r <= in_valid;
            if (in_valid) begin
                oi_r <= i_nxt;
                oq_r <= q_nxt;
            end
        end
    end

    assign out_valid = ov_r;
    assign out_i     = oi_r;
    assign out_q     = oq_r;

    // Loop error terms, taken from the corrected outputs.
    always_comb begin
        err_g = wide_t'(oi_r) * wide_t'(oi_r) - wide_t'(oq_r) * wide_t'(oq_r);
        err_p = wide_t'(oi_r) * wide_t'(oq_r);
    end

    iq_coef_loop #(.COEF_W(COEF_W), .RST_VAL(G_ONE), .SUBTRACT(1'b0)) u_gain (
        .clk(clk), .rst_n(rst_n), .upd(ov_r && cfg_en_g), .err(err_g),
        .shift(cfg.mu_g), .coef(coef_g)
    );

    iq_coef_loop #(.COEF_W(COEF_W), .RST_VAL(0), .SUBTRACT(1'b1)) u_skew (
        .clk(clk), .rst_n(rst_n), .upd(ov_r && cfg_en_p), .err(err_p),
        .shift(cfg.mu_p), .coef(coef_p)
    );

    // Register read mux.
    always_comb begin
        case (cfg_addr)
            ADDR_W'(0): cfg_rdata = DATA_W'({cfg.en_p, cfg.en_g, 3'b000, cfg.mu_p,
                                             3'b000, cfg.mu_g, 3'b000, cfg.dc_k});
            ADDR_W'(1): cfg_rdata = DATA_W'(coef_g);
            ADDR_W'(2): cfg_rdata = DATA_W'(coef_p);
            default:    cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/iq_fix_checker.sv
// Temporal checks on the corrector's strobes, output hold and loop freezing.
module iq_fix_checker #(
    parameter int OUT_W  = 16,
    parameter int COEF_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic [OUT_W-1:0]  out_i,
    input logic [OUT_W-1:0]  out_q,
    input logic              gain_en,
    input logic              phase_en,
    input logic [COEF_W-1:0] coef_g,
    input logic [COEF_W-1:0] coef_p
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_i) && $stable(out_q))); // R1
    AST_GAIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(gain_en) |-> (coef_g == $past(coef_g))); // R7
    AST_SKEW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(phase_en) |-> (coef_p == $past(coef_p))); // R7
    AST_IDLE_NO_ADAPT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(out_valid) |-> (coef_g == $past(coef_g) && coef_p == $past(coef_p))); // R5
endmodule

bind iq_imbalance_fix iq_fix_checker #(.OUT_W(OUT_W), .COEF_W(COEF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q), .gain_en(cfg_en_g), .phase_en(cfg_en_p),
    .coef_g(coef_g), .coef_p(coef_p)
);

// File: tb/iq_imbalance_fix_bench.sv
module iq_imbalance_fix_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [13:0] in_i = '0;
    logic [13:0] in_q = '0;
    logic        out_valid;
    logic [15:0] out_i;
    logic [15:0] out_q;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    // Bench arithmetic model state.
    longint acc_i, acc_q, g_m, p_m, ei_m, eq_m;
    int     k_m, mg_m, mp_m;
    bit     eg_m, ep_m;

    always #4 clk = ~clk;

    iq_imbalance_fix u_iq_imbalance_fix (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    function automatic longint clampv(longint v, int w);
        longint hi = (longint'(1) <<< (w - 1)) - 1;
        longint lo = -(longint'(1) <<< (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic longint pack(int k, int mg, int mp, bit eg, bit ep);
        return longint'(k) | (longint'(mg) << 8) | (longint'(mp) << 16) |
               (longint'(eg) << 24) | (longint'(ep) << 25);
    endfunction

    task automatic check(string req, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_in(string req, longint act, longint lo, longint hi);
        nchk++;
        if (act < lo || act > hi) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=[%0d,%0d]", req, act, lo, hi);
        end
    endtask

    task automatic rd(input int addr, output longint val);
        cfg_addr = 2'(addr);
        #1;
        val = longint'($signed(cfg_rdata));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; cfg_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        acc_i = 0; acc_q = 0; g_m = 65536; p_m = 0; ei_m = 0; eq_m = 0;
        k_m = 10; mg_m = 16; mp_m = 16; eg_m = 0; ep_m = 0;
    endtask

    task automatic wr_cfg(int k, int mg, int mp, bit eg, bit ep);
        cfg_wr = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'(pack(k, mg, mp, eg, ep));
        @(negedge clk);
        cfg_wr = 1'b0;
        k_m = (k < 8) ? 8 : ((k > 16) ? 16 : k);  // R3 clamp
        mg_m = mg; mp_m = mp; eg_m = eg; ep_m = ep;
    endtask

    // Model of one DC-blocker sample (R2); returns floored output.
    task automatic dc_model(input longint x, inout longint acc, output longint y);
        longint d;
        d = (x <<< 16) - acc;
        y = d >>> 16;
        acc = acc + (d >>> k_m);
    endtask

    // One isolated sample with full checking of outputs and coefficients.
    task automatic step(int xi, int xq);
        longint yi, yq, v;
        in_valid = 1'b1; in_i = 14'(xi); in_q = 14'(xq);
        @(negedge clk);
        dc_model(longint'(xi), acc_i, yi);
        dc_model(longint'(xq), acc_q, yq);
        ei_m = clampv(yi, 16);
        eq_m = clampv((g_m * (yq + ((p_m * yi) >>> 16))) >>> 16, 16);
        check("R1 valid", longint'(out_valid), 1);
        check("R2 out_i", longint'($signed(out_i)), ei_m);
        check("R4 out_q", longint'($signed(out_q)), eq_m);
        in_valid = 1'b0;
        @(negedge clk);
        check("R1 hold", longint'($signed(out_q)), eq_m);
        if (eg_m) g_m = clampv(g_m + ((ei_m * ei_m - eq_m * eq_m) >>> mg_m), 19);
        if (ep_m) p_m = clampv(p_m - ((ei_m * eq_m) >>> mp_m), 19);
        rd(1, v); check(eg_m ? "R5 gain" : "R7 gain held", v, g_m);
        rd(2, v); check(ep_m ? "R6 skew" : "R7 skew held", v, p_m);
    endtask

    initial begin
        longint v;
        int vals[7] = '{-8192, -5000, -1, 0, 1, 3000, 8191};
        do_reset();
        // R8 reset state
        check("R8 out_valid", longint'(out_valid), 0);
        check("R8 out_i", longint'(out_i), 0);
        check("R8 out_q", longint'(out_q), 0);
        rd(0, v); check("R8 config", v, pack(10, 16, 16, 0, 0));
        rd(1, v); check("R8 gain", v, 65536);
        rd(2, v); check("R8 skew", v, 0);
        rd(3, v); check("R9 addr3", v, 0);

        // R9 writes to other addresses have no effect
        cfg_wr = 1'b1; cfg_addr = 2'd1; cfg_wdata = 32'h0000_1234;
        @(negedge clk); cfg_wr = 1'b0;
        rd(1, v); check("R9 gain not writable", v, 65536);
        rd(0, v); check("R9 config untouched", v, pack(10, 16, 16, 0, 0));

        // R3 clamping of K
        wr_cfg(3, 16, 16, 0, 0);  rd(0, v); check("R3 low clamp", v, pack(8, 16, 16, 0, 0));
        wr_cfg(31, 16, 16, 0, 0); rd(0, v); check("R3 high clamp", v, pack(16, 16, 16, 0, 0));
        wr_cfg(2, 16, 16, 0, 0);  rd(0, v); check("R3 low clamp2", v, pack(8, 16, 16, 0, 0));

        // R11 constant input decays (K=8), exact per sample (R2)
        for (int n = 0; n < 3000; n++) step(1000, -700);
        check_in("R11 I decay", longint'($signed(out_i)), -1, 1);
        check_in("R11 Q decay", longint'($signed(out_q)), -1, 1);

        // Sweep with loops frozen (R7) and with loops running (R5, R6), K=16
        wr_cfg(16, 12, 12, 0, 0);
        for (int a = 0; a < 7; a++)
            for (int b = 0; b < 7; b++) step(vals[a], vals[b]);
        wr_cfg(16, 12, 12, 1, 1);
        for (int a = 0; a < 7; a++)
            for (int b = 0; b < 7; b++) step(vals[b], vals[a]);

        // R10 blind convergence on an imbalanced four-phase tone
        do_reset();
        wr_cfg(10, 16, 16, 1, 1);
        for (int n = 0; n < 8000; n++) begin
            int xi, xq;
            longint yd;
            case (n % 4)
                0: begin xi = 4000;  xq = 1000;  end
                1: begin xi = 0;     xq = 2000;  end
                2: begin xi = -4000; xq = -1000; end
                default: begin xi = 0; xq = -2000; end
            endcase
            in_valid = 1'b1; in_i = 14'(xi); in_q = 14'(xq);
            dc_model(longint'(xi), acc_i, yd);
            dc_model(longint'(xq), acc_q, yd);
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        wr_cfg(10, 16, 16, 0, 0);
        rd(1, g_m); check_in("R10 gain settles", g_m, 131072 - 2000, 131072 + 2000);
        rd(2, p_m); check_in("R10 skew settles", p_m, -16384 - 600, -16384 + 600);

        // R7 held coefficients and exact correction with non-trivial g, p (R4)
        for (int a = 0; a < 7; a++)
            for (int b = 0; b < 7; b++) step(vals[a], vals[b]);

        // Coefficient and output saturation, step shift 0 (R5, R6, R4)
        do_reset();
        wr_cfg(10, 0, 0, 1, 1);
        step(8191, 0);
        step(0, -8192);
        step(8191, 8191);
        check("R4 positive saturation", longint'($signed(out_q)), 32767);
        rd(1, v); check("R5 gain floor clamp", v, -262144);
        rd(2, v); check("R6 skew clamp", v, p_m);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule